// File: doc/BRIEF.md
# Instruction Fetch Next-Address Unit

This block holds the program counter of a single-cycle processor and works out the address of the next instruction on every rising clock edge. The counter is presented to the instruction memory as a byte address. Each cycle the unit picks one of three flows for the next address. SEQUENTIAL steps forward by one 32-bit word. BRANCH adds a scaled, sign-extended 16-bit displacement to the stepped address. JUMP places a 26-bit word target inside the 256 MB region of the stepped address.

The decoder outside the block supplies a branch-select and a jump-select. The datapath supplies the equality flag from its operand compare. The block also takes the raw instruction word, from which it slices the displacement and the jump target. The flow decision is an enumerated selection with three named values: FLOW_SEQ, FLOW_BRANCH and FLOW_JUMP. The transitions between them are made per cycle:
- JUMP whenever jump-select is high.
- Otherwise BRANCH when both branch-select and the equality flag are high.
- Otherwise SEQUENTIAL.

A synchronous reset returns the counter to address zero.

Top module: `fetch_npc_unit`

## Requirements
- R1: On a rising edge with `rst` high, `pc_out` becomes 0. This holds whatever the select, flag and instruction inputs are.
- R2: With no jump and no taken branch, `pc_out` advances by 4 on each edge. The addition is modulo 2^32.
- R3: With `branch_sel` and `eq_flag` both high and `jump_sel` low, the next `pc_out` is (`pc_out`+4) + (sign-extended `instr[15:0]` shifted left by 2). A displacement with bit 15 set moves the address backward.
- R4: With `branch_sel` high and `eq_flag` low, the next `pc_out` is `pc_out`+4.
- R5: With `eq_flag` high and `branch_sel` low, the flag has no effect, and the next `pc_out` is `pc_out`+4.
- R6: With `jump_sel` high, the next `pc_out` is {(`pc_out`+4)[31:28], `instr[25:0]`, 2'b00}. Instruction bits 31:26 do not affect it.
- R7: A jump wins over a taken branch. When `jump_sel`, `branch_sel` and `eq_flag` are all high, the jump target of R6 is loaded.
- R8: Bits 1:0 of `pc_out` are always 0 once reset has been applied.
- R9: Address arithmetic wraps modulo 2^32. A backward branch from address 0 can reach the top of the address space, and a step from 0xFFFFFFFC gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Current instruction word; bits 15:0 give the displacement, bits 25:0 give the jump target |
| branch_sel | input | 1 | The current instruction is a conditional branch |
| jump_sel | input | 1 | The current instruction is an unconditional jump |
| eq_flag | input | 1 | The two compared operands are equal |
| pc_out | output | 32 | Program counter, a byte address for instruction fetch |

## Verification
The counter is the only state in the block. Any wrong flow decision or wrong target shows on `pc_out` at the very next rising edge, and every later address stays offset from the expected one. The bench therefore compares `pc_out` after every edge against a reference counter stepped with the same inputs. A single mis-selected cycle then shows up immediately, and stays visible as a persistent miscompare. The corners exercised are:
- backward and forward displacements
- the equality flag raised without a branch
- jump-select overlapping a taken branch
- jumps where the region bits of the stepped address differ from those of the current address
- wraparound at the top of the address space

// File: rtl/fetch_npc_pkg.sv
package fetch_npc_pkg;

    typedef enum logic [1:0] {
        FLOW_SEQ    = 2'd0,
        FLOW_BRANCH = 2'd1,
        FLOW_JUMP   = 2'd2
    } flow_e;

endpackage

// File: rtl/npc_word_reg.sv
// Holds the word index of the program counter; byte alignment bits are
// appended at the top level rather than stored.
module npc_word_reg #(
    parameter int IDX_W = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] next_idx,
    output logic [IDX_W-1:0] cur_idx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx <= '0;
        end else begin
            cur_idx <= next_idx;
        end
    end

endmodule

// File: rtl/npc_targets.sv
// Computes the three candidate word indices from the current one.
module npc_targets #(
    parameter int IDX_W = 30,
    parameter int IMM_W = 16,
    parameter int TGT_W = 26
) (
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [IMM_W-1:0] disp,
    input  logic [TGT_W-1:0] jtarget,
    output logic [IDX_W-1:0] seq_idx,
    output logic [IDX_W-1:0] br_idx,
    output logic [IDX_W-1:0] jmp_idx
);

    localparam int REGION_W = IDX_W - TGT_W;
    localparam int EXT_W    = IDX_W - IMM_W;

    logic [IDX_W-1:0] disp_ext;

    always_comb begin
        seq_idx  = cur_idx + IDX_W'(1);
        disp_ext = {{EXT_W{disp[IMM_W-1]}}, disp};
        br_idx   = seq_idx + disp_ext;
    end

    generate
        if (REGION_W > 0) begin : g_region
            assign jmp_idx = {seq_idx[IDX_W-1 -: REGION_W], jtarget};
        end else begin : g_flat
            assign jmp_idx = jtarget[IDX_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/npc_select.sv
// Chooses the flow for this cycle and routes the matching candidate.
module npc_select
    import fetch_npc_pkg::*;
#(
    parameter int IDX_W = 30
) (
    input  logic             branch_sel,
    input  logic             jump_sel,
    input  logic             eq_flag,
    input  logic [IDX_W-1:0] seq_idx,
    input  logic [IDX_W-1:0] br_idx,
    input  logic [IDX_W-1:0] jmp_idx,
    output flow_e            flow,
    output logic [IDX_W-1:0] next_idx
);

    always_comb begin
        flow = FLOW_SEQ;
        if (jump_sel) begin
            flow = FLOW_JUMP;
        end else if (branch_sel && eq_flag) begin
            flow = FLOW_BRANCH;
        end
    end

    always_comb begin
        unique case (flow)
            FLOW_JUMP:   next_idx = jmp_idx;
            FLOW_BRANCH: next_idx = br_idx;
            default:     next_idx = seq_idx;
        endcase
    end

endmodule

// File: rtl/fetch_npc_unit.sv
module fetch_npc_unit
    import fetch_npc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INSTR_W    = 32,
    parameter int WORD_BYTES = 4,
    parameter int IMM_W      = 16,
    parameter int TGT_W      = 26
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic               branch_sel,
    input  logic               jump_sel,
    input  logic               eq_flag,
    output logic [ADDR_W-1:0]  pc_out
);

    localparam int ALIGN_W  = $clog2(WORD_BYTES);
    localparam int IDX_W    = ADDR_W - ALIGN_W;
    localparam int REGION_W = IDX_W - TGT_W;

    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] next_idx;
    logic [IDX_W-1:0] seq_idx;
    logic [IDX_W-1:0] br_idx;
    logic [IDX_W-1:0] jmp_idx;
    flow_e            flow;
    logic             instr_unused;

    assign instr_unused = ^instr[INSTR_W-1:TGT_W];

    npc_word_reg #(.IDX_W(IDX_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .next_idx (next_idx),
        .cur_idx  (cur_idx)
    );

    npc_targets #(.IDX_W(IDX_W), .IMM_W(IMM_W), .TGT_W(TGT_W)) u_tgt (
        .cur_idx (cur_idx),
        .disp    (instr[IMM_W-1:0]),
        .jtarget (instr[TGT_W-1:0]),
        .seq_idx (seq_idx),
        .br_idx  (br_idx),
        .jmp_idx (jmp_idx)
    );

    npc_select #(.IDX_W(IDX_W)) u_sel (
        .branch_sel (branch_sel),
        .jump_sel   (jump_sel),
        .eq_flag    (eq_flag),
        .seq_idx    (seq_idx),
        .br_idx     (br_idx),
        .jmp_idx    (jmp_idx),
        .flow       (flow),
        .next_idx   (next_idx)
    );

    assign pc_out = {cur_idx, {ALIGN_W{1'b0}}};

    // R1
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> pc_out == '0);

    // R2, R4, R5
    a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
        (!jump_sel && !(branch_sel && eq_flag))
        |=> pc_out == $past(pc_out) + ADDR_W'(WORD_BYTES));

    // R3
    a_r3_branch_target: assert property (@(posedge clk) disable iff (rst)
        (branch_sel && eq_flag && !jump_sel)
        |=> pc_out == $past(pc_out) + ADDR_W'(WORD_BYTES)
            + ({{(ADDR_W-IMM_W){$past(instr[IMM_W-1])}}, $past(instr[IMM_W-1:0])}
               << ALIGN_W));

    // R6
    a_r6_jump_low: assert property (@(posedge clk) disable iff (rst)
        jump_sel |=> pc_out[ADDR_W-REGION_W-1:0]
                     == {$past(instr[TGT_W-1:0]), {ALIGN_W{1'b0}}});

    // R7
    a_r7_jump_wins: assert property (@(posedge clk) disable iff (rst)
        (jump_sel && branch_sel && eq_flag)
        |=> pc_out[TGT_W+ALIGN_W-1:0] == {$past(instr[TGT_W-1:0]), {ALIGN_W{1'b0}}});

endmodule

// File: tb/fetch_npc_unit_tb.sv
module fetch_npc_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic        branch_sel = 1'b0;
    logic        jump_sel = 1'b0;
    logic        eq_flag = 1'b0;
    logic [31:0] pc_out;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] pc_model = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #4 clk = ~clk;

    fetch_npc_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .instr      (instr),
        .branch_sel (branch_sel),
        .jump_sel   (jump_sel),
        .eq_flag    (eq_flag),
        .pc_out     (pc_out)
    );

    task automatic drive(input bit r, input bit br, input bit jp, input bit eq,
                         input logic [31:0] iw, input string tag);
        logic [31:0] step;
        logic [31:0] exp;
        @(negedge clk);
        rst = r; branch_sel = br; jump_sel = jp; eq_flag = eq; instr = iw;
        step = pc_model + 32'd4;
        if (r)             exp = 32'd0;
        else if (jp)       exp = {step[31:28], iw[25:0], 2'b00};
        else if (br && eq) exp = step + {{14{iw[15]}}, iw[15:0], 2'b00};
        else               exp = step;
        pc_model = exp;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares pc_out one time unit after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_vec++;
                if (pc_out !== e) begin
                    n_bad++;
                    $display("FAIL %s: pc_out=%h expected=%h", t, pc_out, e);
                end
                n_vec++;
                if (pc_out[1:0] !== 2'b00) begin
                    n_bad++;
                    $display("FAIL R8: pc_out[1:0]=%b expected=00", pc_out[1:0]);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run incomplete, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        drive(1, 0, 0, 0, 32'h0, "R1 reset state");
        drive(1, 1, 1, 1, 32'hFFFF_FFFF, "R1 reset state");
        drive(0, 0, 0, 0, 32'h1234_5678, "R2 sequential");
        drive(0, 0, 0, 0, 32'h0, "R2 sequential");
        drive(0, 0, 0, 0, 32'h0, "R2 sequential");
        drive(0, 0, 0, 1, 32'h0000_0040, "R5 flag without branch");
        drive(0, 1, 0, 0, 32'h0000_0040, "R4 branch not taken");
        drive(0, 1, 0, 1, 32'h0000_0003, "R3 forward branch");
        drive(0, 1, 0, 1, 32'h0000_FFFB, "R3 backward branch");
        drive(0, 0, 1, 0, 32'hFC0A_BCDE, "R6 jump");
        drive(0, 0, 0, 0, 32'h0, "R2 after jump");
        drive(0, 1, 1, 1, 32'h0123_7FFF, "R7 jump over branch");
        drive(0, 1, 1, 0, 32'h0000_0010, "R6 jump with branch not taken");
        drive(1, 1, 1, 1, 32'h03FF_FFFF, "R1 reset overrides jump");
        drive(0, 1, 0, 1, 32'h0000_FFFE, "R9 backward wrap from zero");
        drive(0, 0, 0, 0, 32'h0, "R9 step wraps to zero");
        drive(0, 1, 0, 1, 32'h0000_FFFD, "R9 backward wrap to top");
        drive(0, 0, 1, 0, 32'h0000_0123, "R6 jump keeps high region");
        drive(1, 0, 0, 0, 32'h0, "R1 reset");
        drive(0, 1, 0, 1, 32'h0000_FFFE, "R9 backward wrap from zero");
        drive(0, 0, 1, 0, 32'h0000_0123, "R6 jump region from stepped address");
        drive(0, 1, 0, 1, 32'h0000_7FFF, "R3 largest forward branch");
        drive(0, 1, 0, 1, 32'h0000_8000, "R3 largest backward branch");
        for (int i = 0; i < 60; i++) begin
            logic [31:0] iw;
            iw = (i * 32'h9E37_79B9) ^ (i << 7);
            drive(0, i[0], (i % 7) == 3, i[1], iw, "R2 R3 R4 R6 mixed");
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule